// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is an eight-line general-purpose I/O port behind a byte-wide register interface. Each line has a direction bit and an output bit. Software reaches the output bits through a data window. In that window the word address doubles as a per-line select mask, so a single access can set or clear any subset of lines without first reading the register back. Accesses outside the window and outside the direction register have no effect.

Lines set as outputs drive their pad with the stored output bit, and the pad's output enable follows the direction bit. Lines set as inputs leave the pad undriven. Their pad value passes through a two-stage synchronizer before software can read it. A write to the data window can only change lines that are already outputs. Software therefore switches a line to output first and then writes its value.

Top module: `gpio_mask_port`

## Requirements
- R1: Reset (synchronous, active low) clears the direction and output registers. After reset, `pin_oe`, `pin_out` and `reg_rdata` are all 0x00.
- R2: The direction register is at byte offset 0x400. Bit n set to 1 makes line n an output and set to 0 makes it an input. The register reads back as written, and `pin_oe` equals it.
- R3: The data window is the word-aligned offsets 0x000 to 0x3FC. Address bit n+2 selects line n. A data write loads `reg_wdata[n]` into every selected output line and leaves every other line unchanged.
- R4: A data write has no effect on a selected line that is an input. Writing the same value again after the line becomes an output does update it.
- R5: A data read returns 0 in every bit whose line is not selected by its address bit.
- R6: For a selected line, a data read returns the stored output bit if the line is an output. If the line is an input, it returns the pad value after two synchronizer stages.
- R7: `reg_rdata` is registered. It shows the value addressed at the previous rising clock edge, and that value is taken before a write made at the same edge. A write takes effect at the edge at which `reg_wr` is sampled high.
- R8: `pin_out[n]` equals the output bit for an output line and is 0 for an input line.
- R9: An access to any other offset reads 0x00 and its writes change nothing. This includes offsets with address bits [1:0] nonzero, 0x404, and any address with a bit above bit 10 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = driven |

## Verification
The masked data path is tried with four kinds of mask: all lines (0x3FC), a single line (0x004, 0x010, 0x200), two scattered lines (0x028), and the top pair (0x300). Using several masks shows apart a design that ignores the mask, one that decodes it from the wrong bit offset, and one that drops the zeroing of unselected read bits. Writes are applied while lines are inputs and again after they become outputs, which separates a correctly gated write from one that lands on an input line. Reads are made under mixed directions with different pad patterns, which shows whether each line's value comes from the output register or from the synchronized pad. Unaligned, just-past-the-end and high-bit addresses confirm that the decoder does not alias them into either register.

// File: rtl/gpio_mask_pkg.sv
// Package: shared types for the bit-masked GPIO port.
// Assumes: users import it; holds no logic.
package gpio_mask_pkg;

    // Which register an access address falls into
    typedef enum logic [1:0] {
        RGN_DATA = 2'd0,
        RGN_DIR  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-stage synchronizer, one chain per input line.
// Assumes: pad inputs are asynchronous to clk; stages reset to 0.
module gpio_in_sync #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pad_i,
    output logic [NUM_LINES-1:0] sync_o
);

    logic [NUM_LINES-1:0] stage1_q;
    logic [NUM_LINES-1:0] stage2_q;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // Capture the pad into the first stage, then move it to the second
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[n] <= 1'b0;
                stage2_q[n] <= 1'b0;
            end else begin
                stage1_q[n] <= pad_i[n];
                stage2_q[n] <= stage1_q[n];
            end
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_addr_decode.sv
// Module: splits a byte offset into a register region and a line mask.
// Assumes: word-aligned offsets only; the mask is zero outside the data window.
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned MASK_LSB  = 2,
    parameter int unsigned DIR_OFFS  = 'h400
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output region_e              region_o,
    output logic [NUM_LINES-1:0] mask_o
);

    localparam int unsigned WIN_LSB  = MASK_LSB + NUM_LINES;
    localparam int unsigned WORD_W   = ADDR_W - MASK_LSB;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFFS >> MASK_LSB);

    logic aligned;
    logic in_window;
    logic is_dir;

    // Classify the address into data window, direction register or nothing
    always_comb begin
        aligned   = (addr_i[MASK_LSB-1:0] == '0);
        in_window = aligned && (addr_i[ADDR_W-1:WIN_LSB] == '0);
        is_dir    = aligned && (addr_i[ADDR_W-1:MASK_LSB] == DIR_WORD);
        if (in_window)   region_o = RGN_DATA;
        else if (is_dir) region_o = RGN_DIR;
        else             region_o = RGN_NONE;
        mask_o = in_window ? addr_i[MASK_LSB +: NUM_LINES] : '0;
    end

endmodule

// File: rtl/gpio_line_regs.sv
// Module: per-line direction and output storage with masked, direction-gated writes.
// Assumes: at most one of wr_dir_i / wr_data_i is high in a cycle.
module gpio_line_regs #(
    parameter int unsigned NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_dir_i,
    input  logic                 wr_data_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] dir_o,
    output logic [NUM_LINES-1:0] out_o
);

    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] out_q;

    // Load the whole direction register on a direction write
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '0;
        else if (wr_dir_i) dir_q <= wdata_i;
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // Update one output bit only if selected and already an output
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q[n] <= 1'b0;
            else if (wr_data_i && mask_i[n] && dir_q[n])
                out_q[n] <= wdata_i[n];
        end
    end

    assign dir_o = dir_q;
    assign out_o = out_q;

    // R3
    unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_i |=> (((out_q ^ $past(out_q)) & ~$past(mask_i)) == '0));

    // R4
    input_line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

    // R2
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir_i |=> $stable(dir_q));

endmodule

// File: rtl/gpio_mask_port.sv
// Module: top of the bit-masked GPIO port: decode, registers, sync, read path.
// Assumes: byte register port with no wait states; read data is registered.
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MASK_LSB  = 2,
    parameter int unsigned DIR_OFFS  = 'h400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe
);

    region_e              region;
    logic [NUM_LINES-1:0] sel_mask;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] out_q;
    logic [NUM_LINES-1:0] sync_in;
    logic [NUM_LINES-1:0] rd_next;
    logic [NUM_LINES-1:0] rdata_q;
    logic                 wr_dir;
    logic                 wr_data;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_LINES (NUM_LINES),
        .MASK_LSB  (MASK_LSB),
        .DIR_OFFS  (DIR_OFFS)
    ) i_decode (
        .addr_i   (reg_addr),
        .region_o (region),
        .mask_o   (sel_mask)
    );

    // Turn the write strobe into per-region write enables
    always_comb begin
        wr_dir  = reg_wr && (region == RGN_DIR);
        wr_data = reg_wr && (region == RGN_DATA);
    end

    gpio_line_regs #(
        .NUM_LINES (NUM_LINES)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dir_i  (wr_dir),
        .wr_data_i (wr_data),
        .mask_i    (sel_mask),
        .wdata_i   (reg_wdata),
        .dir_o     (dir_q),
        .out_o     (out_q)
    );

    gpio_in_sync #(
        .NUM_LINES (NUM_LINES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pin_in),
        .sync_o (sync_in)
    );

    // Select the read value: masked line values, direction bits, or zero
    always_comb begin
        case (region)
            RGN_DATA: rd_next = sel_mask & ((dir_q & out_q) | (~dir_q & sync_in));
            RGN_DIR:  rd_next = dir_q;
            default:  rd_next = '0;
        endcase
    end

    // Register the read value so it appears one cycle after the address
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_next;
    end

    assign reg_rdata = rdata_q;
    assign pin_out   = out_q & dir_q;
    assign pin_oe    = dir_q;

    // R5
    unselected_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_DATA) |=> ((reg_rdata & ~$past(sel_mask)) == '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_NONE) |=> (reg_rdata == '0));

    // R8
    undriven_pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_mask_port i_gpio_mask_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Entry: addr[48:37] wr[36] wdata[35:28] pins[27:20] exp_rd[19:12] exp_out[11:4] req[3:0]
    localparam int NV = 25;
    localparam logic [48:0] VEC [NV] = '{
        {12'h400, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1}, // R1 dir reads 0
        {12'h3FC, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 4'd4}, // R4 write to inputs dropped
        {12'h3FC, 1'b0, 8'h00, 8'hA5, 8'hA5, 8'h00, 4'd6}, // R6 inputs via sync
        {12'h400, 1'b1, 8'h0F, 8'h00, 8'h00, 8'h00, 4'd2}, // R2 low nibble out
        {12'h400, 1'b0, 8'h00, 8'h00, 8'h0F, 8'h00, 4'd2}, // R2 readback
        {12'h3FC, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h0F, 4'd4}, // R4 rewrite lands
        {12'h3FC, 1'b0, 8'h00, 8'h00, 8'h0F, 8'h0F, 4'd6}, // R6 mixed
        {12'h3FC, 1'b0, 8'h00, 8'hF0, 8'hFF, 8'h0F, 4'd6}, // R6 mixed
        {12'h004, 1'b1, 8'h00, 8'h00, 8'h00, 8'h0E, 4'd3}, // R3 line 0
        {12'h028, 1'b1, 8'h00, 8'h00, 8'h00, 8'h04, 4'd3}, // R3 lines 1,3
        {12'h010, 1'b0, 8'h00, 8'h00, 8'h04, 8'h04, 4'd5}, // R5 line 2 only
        {12'h004, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h04, 4'd5}, // R5 line 0 only
        {12'h200, 1'b0, 8'h00, 8'h80, 8'h80, 8'h04, 4'd5}, // R5 line 7 input
        {12'h028, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h0E, 4'd3}, // R3 set 1,3
        {12'h3FC, 1'b0, 8'h00, 8'h00, 8'h0E, 8'h0E, 4'd6},
        {12'h404, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h0E, 4'd9}, // R9 past end
        {12'h404, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h0E, 4'd9},
        {12'h3FD, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h0E, 4'd9}, // R9 unaligned
        {12'h800, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h0E, 4'd9}, // R9 high bit
        {12'h400, 1'b0, 8'h00, 8'h00, 8'h0F, 8'h0E, 4'd9},
        {12'h400, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 4'd8}, // R8 all inputs
        {12'h3FC, 1'b0, 8'h00, 8'h3C, 8'h3C, 8'h00, 4'd6},
        {12'h400, 1'b1, 8'hF0, 8'h00, 8'h00, 8'h00, 4'd8}, // R8 high nibble out
        {12'h300, 1'b1, 8'hC0, 8'h00, 8'h00, 8'hC0, 4'd3}, // R3 lines 6,7
        {12'h3FC, 1'b0, 8'h00, 8'h00, 8'hC0, 8'hC0, 4'd6}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Hold pins for the synchronizer, then make one access and sample after the edge
    task automatic step(input logic [48:0] v);
        @(negedge clk);
        pin_in = v[27:20];
        repeat (3) @(negedge clk);
        reg_addr  = v[48:37];
        reg_wr    = v[36];
        reg_wdata = v[35:28];
        @(negedge clk);
        reg_wr = 1'b0;
        chk($sformatf("R%0d pin_out", v[3:0]), pin_out, v[11:4]);
        if (!v[36]) chk($sformatf("R%0d rdata", v[3:0]), reg_rdata, v[19:12]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 rdata", reg_rdata, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R7 read-before-write at the same edge, then new value one cycle later
        @(negedge clk);
        pin_in    = 8'h00;
        reg_addr  = 12'h400;
        reg_wr    = 1'b1;
        reg_wdata = 8'h55;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R7 old dir", reg_rdata, 8'hF0);
        @(negedge clk);
        chk("R7 new dir", reg_rdata, 8'h55);
        chk("R2 oe follows dir", pin_oe, 8'h55);
        chk("R8 out gated", pin_out, 8'h44);

        // R1 reset in the middle of operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 oe mid", pin_oe, 8'h00);
        chk("R1 out mid", pin_out, 8'h00);
        chk("R1 rdata mid", reg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dir after reset", reg_rdata, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule